// File: doc/BRIEF.md
# Acquisition Trigger and Frame Sequencer

This block decides in which clock cycles an analog front end is asked to capture one frame, meaning one sample burst across its channel list. Software controls it through two byte-wide write ports. A write to the command port carries a code: one value arms acquisition, another disarms it, and any other value asks for one frame at once. A write to the gate port turns all triggering off or back on.

While the block is armed and the gate is open, each tick from an external pacer timer produces exactly one frame request. In group mode, acquisition runs from an arm command until a disarm command, and the cycle can repeat any number of times. In counted mode, a programmable frame limit disarms the block by itself after that many paced frames. A separate completion flag records the end of a burst and stays set until software clears it. The flag never holds back the issue of further frames.

Top module: `acq_trig_ctrl`

## Requirements
- R1: After reset, `frame_req`, `busy` and `frame_done` are low and the gate is open.
- R2: When the gate is open, a command write of 0x55 arms acquisition. `busy` is high after the write edge, and the paced-frame count is cleared.
- R3: When the gate is open, a command write of 0xAA disarms acquisition, and `busy` is low after the write edge.
- R4: When the gate is open, a command write of any value other than 0x55 or 0xAA produces a one-cycle `frame_req` after the write edge and leaves `busy` unchanged.
- R5: While armed with the gate open, each cycle with `pacer_tick` high produces a one-cycle `frame_req` that is high after the edge which samples the tick.
- R6: A pacer tick that arrives while disarmed or while the gate is closed produces no frame, and it is not held back for later.
- R7: A gate write of 0x40 closes the gate, and a gate write of 0x00 opens it. A gate write of any other value leaves the gate as it was. While the gate is closed, every command write is ignored.
- R8: In group mode (`mode_counted` = 0), the sequence of arm, paced frames and disarm can be repeated with the same result each time.
- R9: In counted mode (`mode_counted` = 1) with a nonzero `frame_limit` of N, the edge that issues the Nth paced frame since arming also drops `busy`.
- R10: In counted mode, a `frame_limit` of zero means no limit.
- R11: `frame_done` sets on `burst_done` and holds until `clr_done`. If both arrive in the same cycle, the set wins. The flag has no effect on frame issue.
- R12: An arm command while already armed restarts the paced-frame count from zero.
- R13: A disarm command in the same cycle as a pacer tick issues no frame. A single-frame command in the same cycle as a tick issues exactly one `frame_req` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command port write strobe |
| cmd_data | input | 8 | Command byte |
| gate_wr | input | 1 | Gate port write strobe |
| gate_data | input | 8 | Gate byte |
| mode_counted | input | 1 | 0 = group mode, 1 = counted mode |
| frame_limit | input | 32 | Paced-frame limit in counted mode; 0 means no limit |
| pacer_tick | input | 1 | One-cycle pacer pulse |
| burst_done | input | 1 | Front end reports that a burst has finished |
| clr_done | input | 1 | Clears the completion flag |
| frame_req | output | 1 | One-cycle frame request |
| busy | output | 1 | Acquisition armed |
| frame_done | output | 1 | Completion flag |

## Verification
The hardest case to reach from the ports is the automatic disarm in counted mode after the count has been restarted mid-run. Reaching it needs an arm command, some paced frames, a second arm command while still armed, and then exactly the limit number of further ticks. The stimulus builds this sequence from directed ticks. It checks each `frame_req` pulse and `busy` after every edge, so an early stop or a late stop both show up.

The cases where a command and a tick fall in the same cycle are the other hard-to-reach situations. They are driven with both inputs asserted in one cycle.

// File: rtl/atc_pkg.sv
package atc_pkg;
    localparam logic [7:0] CODE_ARM    = 8'h55;
    localparam logic [7:0] CODE_DISARM = 8'hAA;
    localparam logic [7:0] GATE_CLOSE  = 8'h40;
    localparam logic [7:0] GATE_OPEN   = 8'h00;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_ARM,
        CMD_DISARM,
        CMD_SINGLE
    } sw_cmd_e;

    typedef struct packed {
        logic active;
        logic req;
        logic done;
    } ctrl_s;
endpackage

// File: rtl/atc_cmd_decode.sv
module atc_cmd_decode
    import atc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr,
    input  logic [7:0] cmd_data,
    input  logic       gate_wr,
    input  logic [7:0] gate_data,
    output sw_cmd_e    cmd,
    output logic       gate_closed
);
    logic closed_d, closed_q;

    always_comb begin
        closed_d = closed_q;
        if (gate_wr) begin
            if (gate_data == GATE_CLOSE)     closed_d = 1'b1;
            else if (gate_data == GATE_OPEN) closed_d = 1'b0;
        end
        cmd = CMD_NONE;
        if (cmd_wr && !closed_q) begin
            if (cmd_data == CODE_ARM)         cmd = CMD_ARM;
            else if (cmd_data == CODE_DISARM) cmd = CMD_DISARM;
            else                              cmd = CMD_SINGLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) closed_q <= 1'b0;
        else        closed_q <= closed_d;
    end

    assign gate_closed = closed_q;

    // R7
    gate_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_wr && gate_data == GATE_CLOSE) |=> gate_closed);
    // R7
    gate_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_wr && gate_data == GATE_OPEN) |=> !gate_closed);
endmodule

// File: rtl/atc_frame_limit.sv
module atc_frame_limit #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    input  logic [CW-1:0] limit,
    output logic          at_last
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)      cnt_d = '0;
        else if (inc) cnt_d = cnt_q + ONE;
        at_last = (limit != '0) && (cnt_q == limit - ONE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R2
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));
    // R9
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |=> (cnt_q == $past(cnt_q) + ONE));
endmodule

// File: rtl/acq_trig_ctrl.sv
module acq_trig_ctrl
    import atc_pkg::*;
#(
    parameter int LIMIT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_wr,
    input  logic [7:0]         cmd_data,
    input  logic               gate_wr,
    input  logic [7:0]         gate_data,
    input  logic               mode_counted,
    input  logic [LIMIT_W-1:0] frame_limit,
    input  logic               pacer_tick,
    input  logic               burst_done,
    input  logic               clr_done,
    output logic               frame_req,
    output logic               busy,
    output logic               frame_done
);
    sw_cmd_e cmd;
    logic    gate_closed;
    logic    at_last;
    logic    tick_ok;
    logic    limit_stop;
    ctrl_s   st_d, st_q;

    atc_cmd_decode u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_wr     (cmd_wr),
        .cmd_data   (cmd_data),
        .gate_wr    (gate_wr),
        .gate_data  (gate_data),
        .cmd        (cmd),
        .gate_closed(gate_closed)
    );

    atc_frame_limit #(.CW(LIMIT_W)) u_lim (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cmd == CMD_ARM),
        .inc    (tick_ok),
        .limit  (frame_limit),
        .at_last(at_last)
    );

    always_comb begin
        st_d       = st_q;
        tick_ok    = pacer_tick && st_q.active && !gate_closed &&
                     (cmd == CMD_NONE || cmd == CMD_SINGLE);
        limit_stop = tick_ok && mode_counted && at_last;

        if (cmd == CMD_ARM)         st_d.active = 1'b1;
        else if (cmd == CMD_DISARM) st_d.active = 1'b0;
        else if (limit_stop)        st_d.active = 1'b0;

        st_d.req = tick_ok || (cmd == CMD_SINGLE);

        if (burst_done)    st_d.done = 1'b1;
        else if (clr_done) st_d.done = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign frame_req  = st_q.req;
    assign busy       = st_q.active;
    assign frame_done = st_q.done;

    // R7
    gated_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_req |-> $past(!gate_closed));
    // R6
    idle_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_req && $past(cmd != CMD_SINGLE)) |-> $past(busy));
    // R9
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(cmd == CMD_DISARM || (mode_counted && at_last && pacer_tick)));
    // R11
    done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |=> frame_done);
    // R4
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_req && $past(!pacer_tick && !cmd_wr, 1)) |-> 1'b0 || $past(cmd == CMD_SINGLE) || $past(tick_ok));
endmodule

// File: tb/sim_acq_trig_ctrl.sv
`timescale 1ns/1ps
module sim_acq_trig_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [7:0]  cmd_data = '0;
    logic        gate_wr = 1'b0;
    logic [7:0]  gate_data = '0;
    logic        mode_counted = 1'b0;
    logic [31:0] frame_limit = '0;
    logic        pacer_tick = 1'b0;
    logic        burst_done = 1'b0;
    logic        clr_done = 1'b0;
    logic        frame_req, busy, frame_done;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    acq_trig_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
        .gate_wr(gate_wr), .gate_data(gate_data), .mode_counted(mode_counted),
        .frame_limit(frame_limit), .pacer_tick(pacer_tick), .burst_done(burst_done),
        .clr_done(clr_done), .frame_req(frame_req), .busy(busy), .frame_done(frame_done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic cmd(input logic [7:0] b);
        cmd_wr = 1'b1; cmd_data = b;
        step();
        cmd_wr = 1'b0;
    endtask

    task automatic gate(input logic [7:0] b);
        gate_wr = 1'b1; gate_data = b;
        step();
        gate_wr = 1'b0;
    endtask

    task automatic tick(input string req, input logic exp_req);
        pacer_tick = 1'b1;
        step();
        pacer_tick = 1'b0;
        chk(req, frame_req, exp_req);
    endtask

    task automatic t_reset();
        chk("R1 frame_req", frame_req, 0);
        chk("R1 busy", busy, 0);
        chk("R1 frame_done", frame_done, 0);
        cmd(8'h12);
        chk("R1 gate open at reset", frame_req, 1);
        step();
    endtask

    task automatic t_group();
        mode_counted = 1'b0;
        for (int r = 0; r < 2; r++) begin
            tick("R6 tick while idle", 0);
            cmd(8'h55);
            chk("R2 arm", busy, 1);
            chk("R8 no req on arm", frame_req, 0);
            for (int i = 0; i < 3; i++) begin
                tick("R5 paced frame", 1);
                step();
                chk("R5 one cycle pulse", frame_req, 0);
            end
            cmd(8'hAA);
            chk("R3 disarm", busy, 0);
            tick("R8 tick after disarm", 0);
            step();
            chk("R6 not queued", frame_req, 0);
        end
    endtask

    task automatic t_single();
        cmd(8'h3C);
        chk("R4 single req", frame_req, 1);
        chk("R4 busy unchanged", busy, 0);
        step();
        chk("R4 pulse ends", frame_req, 0);
        cmd(8'h55);
        cmd(8'h00);
        chk("R4 single while armed", frame_req, 1);
        chk("R4 busy stays", busy, 1);
        cmd_wr = 1'b1; cmd_data = 8'h77; pacer_tick = 1'b1;
        step();
        cmd_wr = 1'b0; pacer_tick = 1'b0;
        chk("R13 single+tick pulse", frame_req, 1);
        step();
        chk("R13 single+tick one pulse", frame_req, 0);
        cmd_wr = 1'b1; cmd_data = 8'hAA; pacer_tick = 1'b1;
        step();
        cmd_wr = 1'b0; pacer_tick = 1'b0;
        chk("R13 disarm+tick no frame", frame_req, 0);
        chk("R13 disarmed", busy, 0);
    endtask

    task automatic t_gate();
        cmd(8'h55);
        gate(8'h40);
        tick("R6 tick while gated", 0);
        cmd(8'h21);
        chk("R7 single ignored", frame_req, 0);
        cmd(8'hAA);
        chk("R7 disarm ignored", busy, 1);
        gate(8'h13);
        tick("R7 other gate value keeps closed", 0);
        gate(8'h00);
        step();
        chk("R6 gated tick not queued", frame_req, 0);
        tick("R7 reopened", 1);
        cmd(8'hAA);
        gate(8'h40);
        cmd(8'h55);
        chk("R7 arm ignored", busy, 0);
        gate(8'h00);
    endtask

    task automatic t_counted();
        mode_counted = 1'b1;
        frame_limit = 32'd3;
        cmd(8'h55);
        tick("R9 frame 1", 1);
        tick("R9 frame 2", 1);
        chk("R9 still busy", busy, 1);
        tick("R9 frame 3", 1);
        chk("R9 auto stop", busy, 0);
        tick("R9 after limit", 0);
        cmd(8'h55);
        tick("R12 frame a", 1);
        tick("R12 frame b", 1);
        cmd(8'h55);
        tick("R12 restart 1", 1);
        tick("R12 restart 2", 1);
        chk("R12 busy before limit", busy, 1);
        tick("R12 restart 3", 1);
        chk("R12 stop after restart", busy, 0);
        frame_limit = 32'd0;
        cmd(8'h55);
        for (int i = 0; i < 6; i++) tick("R10 unlimited", 1);
        chk("R10 still busy", busy, 1);
        cmd(8'hAA);
        mode_counted = 1'b0;
    endtask

    task automatic t_done();
        burst_done = 1'b1;
        step();
        burst_done = 1'b0;
        chk("R11 set", frame_done, 1);
        step();
        chk("R11 hold", frame_done, 1);
        burst_done = 1'b1; clr_done = 1'b1;
        step();
        burst_done = 1'b0;
        chk("R11 set wins", frame_done, 1);
        step();
        clr_done = 1'b0;
        chk("R11 clear", frame_done, 0);
        burst_done = 1'b1;
        step();
        burst_done = 1'b0;
        cmd(8'h55);
        tick("R11 flag does not block", 1);
        cmd(8'hAA);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_group();
        t_single();
        t_gate();
        t_counted();
        t_done();
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected < 100000 cycles", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule